// File: doc/BRIEF.md
# Match-Compare Event Timer

This block is a 32-bit event timer that a processor programs through a four-word register window on a plain single-cycle bus with write enable, word address, write data and read data. A counter steps by one on every cycle where the synchronous sleep-tick pulse is high and counting is switched on. When the count lands on a programmed compare value, the block raises its interrupt line. The line stays high until software acknowledges by switching counting off.

Software normally starts an event in four steps. It holds the count at zero by writing 1 to the zeroing word, then releases it by writing 0. It then writes the compare value and turns counting on. A second control bit makes the counter fall back to zero on the tick after a hit, which gives a periodic event stream. Without that bit, counting carries on past the compare value.

Top module: `mtmr_top`

## Requirements
- R1: After a synchronous active-low reset, every register word reads 0 and `irq_o` is low.
- R2: Word address 0 holds the compare value, and all 32 bits read back as written. Word address 2 is control: bit 0 is run and bit 1 is auto-restart, and the other bits read back as 0. Word address 3 is the zeroing word: bit 0 is kept and the other bits read back as 0.
- R3: A write to word address 1, which returns the live count, changes neither the count nor any stored register.
- R4: The count rises by exactly one on each cycle where `tick_i` is high, run is 1 and the zeroing bit is 0. In every other cycle it holds its value.
- R5: While the zeroing bit is 1, the count is forced to 0 on every clock, whatever `tick_i` does.
- R6: On the tick that moves the count onto the compare value while run is 1, `irq_o` rises at the same clock edge that loads that count. Before that edge it is low.
- R7: Once high, `irq_o` stays high while run remains 1, including on later ticks past the compare value. A control write with bit 0 at 0 drives `irq_o` low from that write's clock edge and stops the count.
- R8: With auto-restart set, the tick that follows a hit returns the count to 0, and counting then goes on, so the next hit comes after a further compare-value ticks.
- R9: With auto-restart clear, the tick after a hit moves the count to the compare value plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_i | input | 1 | Sleep-tick pulse, one clock wide, already synchronous |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Word address of the register window |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, valid in the same cycle |
| irq_o | output | 1 | Event interrupt line, rising edge signals a hit |

## Verification
The interrupt check assumes that the compare value is not rewritten in the cycle where the count lands on it, so the assertion that ties a rising interrupt to equality includes a stability condition on the compare value. The checks also assume that `tick_i` is a single-clock pulse. The bench writes the compare value only while counting is stopped or the count is held at zero. It drives the tick as isolated one-cycle pulses on the falling edge, and it changes bus inputs only on falling edges. The compare values used are 0xF and 0x20, so every hit and every auto-restart is reached in a few dozen ticks.

// File: rtl/mtmr_pkg.sv
// Shared definitions for the match-compare timer.
// Assumes a word-addressed window of four registers.
package mtmr_pkg;

    localparam int unsigned ADDR_W = 2;

    // Word addresses inside the register window
    typedef enum logic [ADDR_W-1:0] {
        REG_MATCH = 2'd0,
        REG_COUNT = 2'd1,
        REG_CTRL  = 2'd2,
        REG_ZERO  = 2'd3
    } reg_sel_e;

    // Bit positions inside the control word
    localparam int unsigned CTRL_RUN_BIT  = 0;
    localparam int unsigned CTRL_AUTO_BIT = 1;

    // Bit position of the hold-at-zero flag inside the zeroing word
    localparam int unsigned ZERO_BIT = 0;

endpackage

// File: rtl/mtmr_regs.sv
// Register window of the timer: the stored compare value, the control bits
// and the zeroing flag, plus a combinational read mux.
// Assumes a single-cycle bus: a write takes effect at the clock edge where
// we_i is high, and read data follows the address in the same cycle.
module mtmr_regs
    import mtmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [DATA_W-1:0] count_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [DATA_W-1:0] match_o,
    output logic              run_o,
    output logic              auto_o,
    output logic              zero_o
);

    localparam logic [DATA_W-1:0] ZERO_WORD = '0;

    reg_sel_e sel;
    logic     wr_match;
    logic     wr_ctrl;
    logic     wr_zero;

    // Decode the addressed register for this cycle
    always_comb begin
        sel      = reg_sel_e'(addr_i);
        wr_match = we_i && (sel == REG_MATCH);
        wr_ctrl  = we_i && (sel == REG_CTRL);
        wr_zero  = we_i && (sel == REG_ZERO);
    end

    // Hold the compare value
    always_ff @(posedge clk) begin
        if (!rst_n)        match_o <= ZERO_WORD;
        else if (wr_match) match_o <= wdata_i;
    end

    // Hold the two control bits; the remaining bits are dropped
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_o  <= 1'b0;
            auto_o <= 1'b0;
        end else if (wr_ctrl) begin
            run_o  <= wdata_i[CTRL_RUN_BIT];
            auto_o <= wdata_i[CTRL_AUTO_BIT];
        end
    end

    // Hold the level-style zeroing flag
    always_ff @(posedge clk) begin
        if (!rst_n)       zero_o <= 1'b0;
        else if (wr_zero) zero_o <= wdata_i[ZERO_BIT];
    end

    // Return the addressed word, with the count taken live from the counter
    always_comb begin
        rdata_o = ZERO_WORD;
        unique case (sel)
            REG_MATCH: rdata_o = match_o;
            REG_COUNT: rdata_o = count_i;
            REG_CTRL: begin
                rdata_o[CTRL_RUN_BIT]  = run_o;
                rdata_o[CTRL_AUTO_BIT] = auto_o;
            end
            REG_ZERO:  rdata_o[ZERO_BIT] = zero_o;
            default:   rdata_o = ZERO_WORD;
        endcase
    end

    AST_COUNT_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == REG_COUNT) |=> ($stable(match_o) && $stable(run_o) && $stable(auto_o) && $stable(zero_o))); // R3

endmodule

// File: rtl/mtmr_counter.sv
// Tick counter of the timer. It steps by one per qualified tick, returns to
// zero after a hit when auto-restart is set, and is held at zero by the
// zeroing flag. It also gives the value the next step would load.
// Assumes tick_i is a one-clock pulse that is already synchronous to clk.
module mtmr_counter #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              run_i,
    input  logic              auto_i,
    input  logic              zero_i,
    input  logic [DATA_W-1:0] match_i,
    output logic [DATA_W-1:0] count_o,
    output logic              step_o,
    output logic [DATA_W-1:0] next_o
);

    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
    localparam logic [DATA_W-1:0] NONE = '0;

    logic at_match;

    // Work out whether a step happens and which value it would load
    always_comb begin
        step_o   = tick_i && run_i && !zero_i;
        at_match = (count_o == match_i);
        next_o   = (auto_i && at_match) ? NONE : count_o + ONE;
    end

    // Advance, hold, or force the count to zero
    always_ff @(posedge clk) begin
        if (!rst_n)      count_o <= NONE;
        else if (zero_i) count_o <= NONE;
        else if (step_o) count_o <= next_o;
    end

    AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        zero_i |=> (count_o == NONE)); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!zero_i && !(tick_i && run_i)) |=> $stable(count_o)); // R4

    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && !zero_i && !(auto_i && count_o == match_i)) |=> (count_o == $past(count_o) + ONE)); // R4

    AST_AUTO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && run_i && !zero_i && auto_i && count_o == match_i) |=> (count_o == NONE)); // R8

endmodule

// File: rtl/mtmr_event.sv
// Event generator of the timer. It sets a sticky hit flag when a step is
// about to load the compare value, and it gates the flag with run.
// Assumes step_i and next_i come from the counter for the same cycle.
module mtmr_event #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [DATA_W-1:0] next_i,
    input  logic [DATA_W-1:0] match_i,
    input  logic              run_i,
    output logic              irq_o
);

    logic hit;
    logic hit_q;

    // Flag the step that lands the count on the compare value
    always_comb hit = step_i && (next_i == match_i);

    // Keep the hit flag until run is switched off
    always_ff @(posedge clk) begin
        if (!rst_n)      hit_q <= 1'b0;
        else if (!run_i) hit_q <= 1'b0;
        else if (hit)    hit_q <= 1'b1;
    end

    // Drive the line only while counting is on, so acknowledge drops it at once
    always_comb irq_o = hit_q && run_i;

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q && run_i) |=> hit_q); // R7

    AST_IRQ_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !hit_q); // R7

    AST_IRQ_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_q && !step_i) |=> !hit_q); // R6

endmodule

// File: rtl/mtmr_top.sv
// Match-compare event timer: a register window, a tick counter and an
// interrupt generator. Reads are combinational and writes are single-cycle.
// Assumes tick_i is a synchronous one-clock pulse and that software does not
// rewrite the compare value in the cycle where the count reaches it.
module mtmr_top
    import mtmr_pkg::*;
#(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o
);

    logic [DATA_W-1:0] match_val;
    logic [DATA_W-1:0] count_val;
    logic [DATA_W-1:0] next_val;
    logic              run;
    logic              auto_rst;
    logic              zero_hold;
    logic              step;

    mtmr_regs #(.DATA_W(DATA_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_we_i),
        .addr_i  (bus_addr_i),
        .wdata_i (bus_wdata_i),
        .count_i (count_val),
        .rdata_o (bus_rdata_o),
        .match_o (match_val),
        .run_o   (run),
        .auto_o  (auto_rst),
        .zero_o  (zero_hold)
    );

    mtmr_counter #(.DATA_W(DATA_W)) i_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .run_i   (run),
        .auto_i  (auto_rst),
        .zero_i  (zero_hold),
        .match_i (match_val),
        .count_o (count_val),
        .step_o  (step),
        .next_o  (next_val)
    );

    mtmr_event #(.DATA_W(DATA_W)) i_event (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step),
        .next_i  (next_val),
        .match_i (match_val),
        .run_i   (run),
        .irq_o   (irq_o)
    );

    AST_IRQ_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_o) && $stable(match_val)) |-> (count_val == match_val)); // R6

endmodule

// File: tb/test_mtmr_top.sv
module test_mtmr_top;
    import mtmr_pkg::*;

    localparam int unsigned DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          we = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk; // 250 MHz

    mtmr_top #(.DATA_W(DW)) i_mtmr_top (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq)
    );

    // {we, addr, wdata, expected read, requirement}
    localparam int NV = 14;
    localparam logic [70:0] VEC [NV] = '{
        {1'b0, 2'd0, 32'h0,         32'h0,         4'd2}, // R2 compare reads 0
        {1'b1, 2'd0, 32'h1234_5678, 32'h0,         4'd2},
        {1'b0, 2'd0, 32'h0,         32'h1234_5678, 4'd2}, // R2 compare full width
        {1'b1, 2'd2, 32'hFFFF_FFFC, 32'h0,         4'd2},
        {1'b0, 2'd2, 32'h0,         32'h0,         4'd2}, // R2 upper control bits dropped
        {1'b1, 2'd2, 32'hFFFF_FFFE, 32'h0,         4'd2},
        {1'b0, 2'd2, 32'h0,         32'h2,         4'd2}, // R2 auto-restart bit only
        {1'b1, 2'd1, 32'hDEAD_BEEF, 32'h0,         4'd3},
        {1'b0, 2'd1, 32'h0,         32'h0,         4'd3}, // R3 count write ignored
        {1'b0, 2'd0, 32'h0,         32'h1234_5678, 4'd3}, // R3 compare untouched
        {1'b1, 2'd3, 32'hFFFF_FFFE, 32'h0,         4'd2},
        {1'b0, 2'd3, 32'h0,         32'h0,         4'd2}, // R2 zeroing upper bits dropped
        {1'b1, 2'd2, 32'h0,         32'h0,         4'd2},
        {1'b0, 2'd2, 32'h0,         32'h0,         4'd2}  // R2 control cleared
    };

    task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [DW-1:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int a = 0; a < 4; a++) rd(2'(a), 32'h0, "R1");
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // Register map table
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][70]) wr(VEC[v][69:68], VEC[v][67:36]);
            else rd(VEC[v][69:68], VEC[v][35:4], $sformatf("R%0d table %0d", VEC[v][3:0], v));
        end

        // R4 counting and holding
        wr(REG_ZERO, 1); wr(REG_ZERO, 0);
        wr(REG_MATCH, 32'h20); wr(REG_CTRL, 1);
        ticks(5);
        repeat (3) @(negedge clk);
        rd(REG_COUNT, 5, "R4 five ticks");
        wr(REG_CTRL, 0);
        ticks(3);
        rd(REG_COUNT, 5, "R4 hold when stopped");

        // R5 zeroing holds the count
        wr(REG_CTRL, 1);
        wr(REG_ZERO, 1);
        rd(REG_COUNT, 0, "R5 forced zero");
        ticks(3);
        rd(REG_COUNT, 0, "R5 held through ticks");
        wr(REG_ZERO, 0);
        ticks(2);
        rd(REG_COUNT, 2, "R5 released");

        // R6 hit at compare value 0xF
        wr(REG_CTRL, 0);
        wr(REG_ZERO, 1); wr(REG_ZERO, 0);
        wr(REG_MATCH, 32'hF); wr(REG_CTRL, 1);
        ticks(14);
        rd(REG_COUNT, 14, "R6 before hit");
        chk("R6 irq low before hit", {31'b0, irq}, 32'h0);
        ticks(1);
        #1;
        chk("R6 irq at hit", {31'b0, irq}, 32'h1);
        rd(REG_COUNT, 32'hF, "R6 count at hit");

        // R9 and R7: past the compare value, line stays up
        ticks(1);
        rd(REG_COUNT, 32'h10, "R9 past compare");
        chk("R7 irq held", {31'b0, irq}, 32'h1);
        wr(REG_CTRL, 0);
        #1;
        chk("R7 irq dropped", {31'b0, irq}, 32'h0);
        ticks(2);
        rd(REG_COUNT, 32'h10, "R7 count stopped");

        // R8 auto-restart
        wr(REG_ZERO, 1); wr(REG_ZERO, 0);
        wr(REG_CTRL, 3);
        ticks(15);
        #1;
        chk("R8 irq first hit", {31'b0, irq}, 32'h1);
        ticks(1);
        rd(REG_COUNT, 0, "R8 back to zero");
        ticks(1);
        rd(REG_COUNT, 1, "R8 keeps running");
        wr(REG_CTRL, 0);
        #1;
        chk("R7 ack in auto mode", {31'b0, irq}, 32'h0);
        wr(REG_CTRL, 3);
        ticks(13);
        #1;
        chk("R8 no hit early", {31'b0, irq}, 32'h0);
        ticks(1);
        #1;
        chk("R8 second hit", {31'b0, irq}, 32'h1);

        // R1 reset clears everything mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
        for (int a = 0; a < 4; a++) rd(2'(a), 32'h0, "R1 after reset");

        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

endmodule